// File: doc/BRIEF.md
# Sticky Error Status Register with Message Trigger

This block holds four hardware error flags in a 16-bit configuration register and turns new errors into single-cycle message requests. Its four error sources are a software-raised event, a thermal trip, a locked access that targets memory outside DRAM, and a DRAM throttling condition. Each flag stays set until software writes a 1 to its bit. The other twelve bits are fixed at zero.

A flag that goes from 0 to 1 raises a system-error request. This happens only when that flag's error-command enable is set and the PCI-command system-error enable is also set. The non-thermal flags record their event whether or not a message goes out. Thermal trips are handled differently. Each trip point is routed to exactly one of three message kinds: SMI, SCI or system error. The thermal flag is set only when a message is actually sent for a trip. While the thermal flag is set, further trips are dropped.

The flags use a power-good reset, so a warm reset does not clear them. The message outputs use the warm reset.

Top module: `err_status_reg`

## Requirements
- R1: A power-good reset clears the register, so a read at offset C8h returns 0000h. A read at any other offset returns 0000h whatever the flag state.
- R2: Bits 15:13, 10, 8 and 6:0 always read 0, and no write changes them.
- R3: The flags sit at fixed bit positions: software event at bit 12, thermal at bit 11, lock at bit 9 and throttle at bit 7. A flag's event sets it. The flag clears only on a write at offset C8h that has a 1 in the flag's bit and the byte enable for that bit's lane set: be[0] covers bits 7:0 and be[1] covers bits 15:8. Writing a 0, or writing at another offset, leaves the flags unchanged.
- R4: The software, lock and throttle flags are set by their events whatever the enable settings are.
- R5: `serr_req_o` is high for exactly one cycle, the cycle after the clock edge on which a non-thermal flag goes from 0 to 1. This requires that flag's `errcmd_en_i` bit to be 1 (bit 0 software, bit 1 lock, bit 2 throttle) and `pcicmd_serr_en_i` to be 1.
- R6: An event on a flag that is already set produces no message. When several flags rise in the same cycle, they produce one single-cycle pulse.
- R7: A thermal trip whose routing selects exactly one target sends one pulse on the matching output (`smi_req_o`, `sci_req_o` or `serr_req_o`) and sets the thermal flag. A system-error route sends only when `pcicmd_serr_en_i` is 1; otherwise nothing is sent and the flag stays clear. If several trips can be sent in the same cycle, the lowest index wins.
- R8: A trip point whose routing selects no target, or two or more targets, sends no message and leaves the thermal flag unchanged.
- R9: While the thermal flag is set, a new trip sends no message.
- R10: When an event and a clearing write for the same flag arrive in the same cycle, the flag ends up set. A message is raised only if the flag was clear beforehand.
- R11: A warm reset (`rst_ni`) clears the message outputs and keeps the flags. The power-good reset (`pg_rst_ni`) clears the flags.
- R12: Reading the register does not change the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Warm reset, active low, asynchronous (message logic) |
| pg_rst_ni | input | 1 | Power-good reset, active low, asynchronous (flags) |
| cfg_addr_i | input | ADDR_W | Configuration byte offset |
| cfg_wr_i | input | 1 | Write strobe |
| cfg_wdata_i | input | 16 | Write data |
| cfg_be_i | input | 2 | Byte enables |
| cfg_rdata_o | output | 16 | Read data, 0 when the offset does not match |
| sw_evt_i | input | 1 | Software event pulse |
| lock_evt_i | input | 1 | Lock-to-non-DRAM pulse |
| throttle_evt_i | input | 1 | DRAM throttle pulse |
| trip_i | input | N_TRIP | Thermal trip pulses, one per trip point |
| route_smi_i | input | N_TRIP | Trip point routed to SMI |
| route_sci_i | input | N_TRIP | Trip point routed to SCI |
| route_serr_i | input | N_TRIP | Trip point routed to system error |
| errcmd_en_i | input | 3 | Per-flag system-error enables (software, lock, throttle) |
| pcicmd_serr_en_i | input | 1 | Global system-error enable |
| serr_req_o | output | 1 | System-error message request pulse |
| smi_req_o | output | 1 | SMI message request pulse |
| sci_req_o | output | 1 | SCI message request pulse |

## Verification
Two things can happen on the same edge: a software clear-by-write and a hardware set of the same flag. The bench drives a clearing write and a throttle event in one cycle, first with the flag already set and then with a lock event while that flag is clear. In both cases the flag must read back as set. A pulse is expected only in the second case. Simultaneous rises of two flags are also provoked, and the scoreboard expects exactly one pulse followed by an idle cycle.

// File: rtl/err_sts_pkg.sv
package err_sts_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned BE_W   = REG_W / 8;
  localparam int unsigned FLAG_N = 4;
  localparam int unsigned IDX_SW = 0;
  localparam int unsigned IDX_TH = 1;
  localparam int unsigned IDX_LK = 2;
  localparam int unsigned IDX_DT = 3;
  // bits 12, 11, 9, 7
  localparam logic [REG_W-1:0] FLAG_MASK = 16'h1A80;

  function automatic int unsigned flag_pos(input int unsigned idx);
    case (idx)
      IDX_SW:  return 12;
      IDX_TH:  return 11;
      IDX_LK:  return 9;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/err_flag_bank.sv
module err_flag_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         pg_rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] flag_q;

  for (genvar g = 0; g < N; g++) begin : g_flag
    // set beats clear
    always_ff @(posedge clk_i or negedge pg_rst_ni) begin
      if (!pg_rst_ni) flag_q[g] <= 1'b0;
      else            flag_q[g] <= set_i[g] | (flag_q[g] & ~clr_i[g]);
    end
    assign rise_o[g] = set_i[g] & ~flag_q[g];
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/err_therm_route.sv
module err_therm_route #(
  parameter int unsigned N_TRIP = 2
) (
  input  logic [N_TRIP-1:0] trip_i,
  input  logic [N_TRIP-1:0] route_smi_i,
  input  logic [N_TRIP-1:0] route_sci_i,
  input  logic [N_TRIP-1:0] route_serr_i,
  input  logic              serr_en_i,
  input  logic              flag_i,
  output logic              set_o,
  output logic              smi_o,
  output logic              sci_o,
  output logic              serr_o
);
  logic [N_TRIP-1:0] sendable;

  for (genvar t = 0; t < N_TRIP; t++) begin : g_trip
    logic [2:0] sel;
    assign sel = {route_smi_i[t], route_sci_i[t], route_serr_i[t]};
    assign sendable[t] = trip_i[t] & ($countones(sel) == 1) &
                         (route_smi_i[t] | route_sci_i[t] | (route_serr_i[t] & serr_en_i));
  end

  // lowest sendable trip wins; nothing while flag held
  always_comb begin
    set_o  = 1'b0;
    smi_o  = 1'b0;
    sci_o  = 1'b0;
    serr_o = 1'b0;
    for (int t = 0; t < int'(N_TRIP); t++) begin
      if (!set_o && !flag_i && sendable[t]) begin
        set_o  = 1'b1;
        smi_o  = route_smi_i[t];
        sci_o  = route_sci_i[t];
        serr_o = route_serr_i[t];
      end
    end
  end
endmodule

// File: rtl/err_msg_gen.sv
module err_msg_gen #(
  parameter int unsigned N      = 4,
  parameter int unsigned TH_IDX = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] en_i,
  input  logic         pcicmd_i,
  input  logic         th_smi_i,
  input  logic         th_sci_i,
  output logic         serr_o,
  output logic         smi_o,
  output logic         sci_o
);
  logic serr_d, smi_d, sci_d;

  assign serr_d = pcicmd_i & |(rise_i & en_i);
  assign smi_d  = rise_i[TH_IDX] & th_smi_i;
  assign sci_d  = rise_i[TH_IDX] & th_sci_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      serr_o <= 1'b0;
      smi_o  <= 1'b0;
      sci_o  <= 1'b0;
    end else begin
      serr_o <= serr_d;
      smi_o  <= smi_d;
      sci_o  <= sci_d;
    end
  end
endmodule

// File: rtl/err_status_reg.sv
module err_status_reg
  import err_sts_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] CFG_OFFSET = 8'hC8,
  parameter int unsigned       N_TRIP     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pg_rst_ni,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic              cfg_wr_i,
  input  logic [REG_W-1:0]  cfg_wdata_i,
  input  logic [BE_W-1:0]   cfg_be_i,
  output logic [REG_W-1:0]  cfg_rdata_o,
  input  logic              sw_evt_i,
  input  logic              lock_evt_i,
  input  logic              throttle_evt_i,
  input  logic [N_TRIP-1:0] trip_i,
  input  logic [N_TRIP-1:0] route_smi_i,
  input  logic [N_TRIP-1:0] route_sci_i,
  input  logic [N_TRIP-1:0] route_serr_i,
  input  logic [2:0]        errcmd_en_i,
  input  logic              pcicmd_serr_en_i,
  output logic              serr_req_o,
  output logic              smi_req_o,
  output logic              sci_req_o
);
  logic              hit;
  logic [FLAG_N-1:0] flag_set, flag_clr, flag_q, flag_rise, msg_en;
  logic              th_set, th_smi, th_sci, th_serr;
  logic [REG_W-1:0]  rd_img;

  assign hit = (cfg_addr_i == CFG_OFFSET);

  for (genvar g = 0; g < FLAG_N; g++) begin : g_clr
    localparam int unsigned P = flag_pos(g);
    assign flag_clr[g] = cfg_wr_i & hit & cfg_wdata_i[P] & cfg_be_i[P/8];
  end

  err_therm_route #(.N_TRIP(N_TRIP)) u_route (
    .trip_i       (trip_i),
    .route_smi_i  (route_smi_i),
    .route_sci_i  (route_sci_i),
    .route_serr_i (route_serr_i),
    .serr_en_i    (pcicmd_serr_en_i),
    .flag_i       (flag_q[IDX_TH]),
    .set_o        (th_set),
    .smi_o        (th_smi),
    .sci_o        (th_sci),
    .serr_o       (th_serr)
  );

  always_comb begin
    flag_set         = '0;
    flag_set[IDX_SW] = sw_evt_i;
    flag_set[IDX_TH] = th_set;
    flag_set[IDX_LK] = lock_evt_i;
    flag_set[IDX_DT] = throttle_evt_i;
    msg_en           = '0;
    msg_en[IDX_SW]   = errcmd_en_i[0];
    msg_en[IDX_TH]   = th_serr;
    msg_en[IDX_LK]   = errcmd_en_i[1];
    msg_en[IDX_DT]   = errcmd_en_i[2];
  end

  err_flag_bank #(.N(FLAG_N)) u_flags (
    .clk_i     (clk_i),
    .pg_rst_ni (pg_rst_ni),
    .set_i     (flag_set),
    .clr_i     (flag_clr),
    .flag_o    (flag_q),
    .rise_o    (flag_rise)
  );

  err_msg_gen #(.N(FLAG_N), .TH_IDX(IDX_TH)) u_msg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (flag_rise),
    .en_i     (msg_en),
    .pcicmd_i (pcicmd_serr_en_i),
    .th_smi_i (th_smi),
    .th_sci_i (th_sci),
    .serr_o   (serr_req_o),
    .smi_o    (smi_req_o),
    .sci_o    (sci_req_o)
  );

  always_comb begin
    rd_img = '0;
    for (int i = 0; i < int'(FLAG_N); i++) rd_img[flag_pos(i)] = flag_q[i];
  end

  assign cfg_rdata_o = hit ? rd_img : '0;
endmodule

// File: rtl/err_status_chk.sv
module err_status_chk
  import err_sts_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pg_rst_ni,
  input logic              cfg_wr_i,
  input logic [REG_W-1:0]  cfg_wdata_i,
  input logic [REG_W-1:0]  cfg_rdata_i,
  input logic [FLAG_N-1:0] flags_i,
  input logic [FLAG_N-1:0] clr_i,
  input logic              pcicmd_i,
  input logic              serr_i,
  input logic              smi_i,
  input logic              sci_i
);
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni || !pg_rst_ni)
    (cfg_rdata_i & ~FLAG_MASK) == '0); // R2

  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni || !pg_rst_ni)
    (($past(flags_i) & ~$past(clr_i)) & ~flags_i) == '0); // R3

  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni || !pg_rst_ni)
    (cfg_wr_i && ((cfg_wdata_i & FLAG_MASK) == '0)) |=> ((flags_i & $past(flags_i)) == $past(flags_i))); // R3

  AST_SERR_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni || !pg_rst_ni)
    serr_i |-> ((flags_i & ~$past(flags_i)) != '0)); // R5

  AST_SERR_GLOBAL_EN: assert property (@(posedge clk_i) disable iff (!rst_ni || !pg_rst_ni)
    serr_i |-> $past(pcicmd_i)); // R5

  AST_THERM_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni || !pg_rst_ni)
    (smi_i || sci_i) |-> (flags_i[IDX_TH] && !$past(flags_i[IDX_TH]))); // R9

  AST_ONE_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni || !pg_rst_ni)
    !(smi_i && sci_i)); // R7
endmodule

bind err_status_reg err_status_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pg_rst_ni   (pg_rst_ni),
  .cfg_wr_i    (cfg_wr_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_rdata_i (cfg_rdata_o),
  .flags_i     (flag_q),
  .clr_i       (flag_clr),
  .pcicmd_i    (pcicmd_serr_en_i),
  .serr_i      (serr_req_o),
  .smi_i       (smi_req_o),
  .sci_i       (sci_req_o)
);

// File: tb/sim_err_status_reg.sv
module sim_err_status_reg;
  localparam time CLK_P = 8ns;

  logic        clk = 1'b0, rst_n = 1'b0, pg_rst_n = 1'b0;
  logic [7:0]  cfg_addr = 8'hC8;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [1:0]  cfg_be = '0;
  logic [15:0] cfg_rdata;
  logic        sw_evt = 0, lock_evt = 0, thr_evt = 0;
  logic [1:0]  trip = '0, r_smi = '0, r_sci = '0, r_serr = '0;
  logic [2:0]  errcmd = 3'b111;
  logic        pcicmd = 1'b1;
  logic        serr, smi, sci;

  int checks = 0, fails = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  err_status_reg u0 (
    .clk_i(clk), .rst_ni(rst_n), .pg_rst_ni(pg_rst_n),
    .cfg_addr_i(cfg_addr), .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata),
    .cfg_be_i(cfg_be), .cfg_rdata_o(cfg_rdata),
    .sw_evt_i(sw_evt), .lock_evt_i(lock_evt), .throttle_evt_i(thr_evt),
    .trip_i(trip), .route_smi_i(r_smi), .route_sci_i(r_sci), .route_serr_i(r_serr),
    .errcmd_en_i(errcmd), .pcicmd_serr_en_i(pcicmd),
    .serr_req_o(serr), .smi_req_o(smi), .sci_req_o(sci)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // monitor: compare {serr,smi,sci} after each edge against the scoreboard
  initial forever begin
    @(posedge clk);
    #2;
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, {13'd0, serr, smi, sci}, {13'd0, e});
    end
  end

  // driver: inputs already set at negedge; push expectation, run one edge
  task automatic tick(input logic [2:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    sw_evt = 0; lock_evt = 0; thr_evt = 0; trip = '0;
    cfg_wr = 0; cfg_addr = 8'hC8;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [1:0] be,
                    input logic [2:0] exp, input string tag);
    cfg_addr = a; cfg_wdata = d; cfg_be = be; cfg_wr = 1;
    tick(exp, tag);
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
    cfg_addr = a;
    #1;
    chk(tag, cfg_rdata, exp);
    cfg_addr = 8'hC8;
  endtask

  task automatic clr_all();
    wr(8'hC8, 16'hFFFF, 2'b11, 3'b000, "clear");
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; pg_rst_n = 1;
    @(negedge clk);
    rd(8'hC8, 16'h0000, "R1 reset value");
    chk("R11 pulse reset", {13'd0, serr, smi, sci}, 16'h0);

    // lock event, enabled
    lock_evt = 1; tick(3'b100, "R5 lock rise pulse");
    rd(8'hC8, 16'h0200, "R3 lock flag bit9");
    rd(8'hCA, 16'h0000, "R1 other offset reads 0");
    tick(3'b000, "R5 pulse one cycle");
    lock_evt = 1; tick(3'b000, "R6 no pulse when set");
    rd(8'hC8, 16'h0200, "R12 read no side effect");

    wr(8'hC8, 16'hFFFF, 2'b01, 3'b000, "R3 wrong lane");
    rd(8'hC8, 16'h0200, "R3 wrong lane keeps");
    wr(8'hC8, 16'h0000, 2'b11, 3'b000, "R3 zero write");
    rd(8'hC8, 16'h0200, "R3 zero write keeps");
    wr(8'hCC, 16'hFFFF, 2'b11, 3'b000, "R3 other offset write");
    rd(8'hC8, 16'h0200, "R3 other offset keeps");
    wr(8'hC8, 16'hFFFF, 2'b10, 3'b000, "R3 clear");
    rd(8'hC8, 16'h0000, "R3 R2 cleared and reserved 0");

    // enables off
    pcicmd = 0;
    thr_evt = 1; tick(3'b000, "R4 no msg global off");
    rd(8'hC8, 16'h0080, "R4 throttle set anyway");
    clr_all();
    pcicmd = 1; errcmd = 3'b010;
    sw_evt = 1; tick(3'b000, "R5 per-flag enable off");
    rd(8'hC8, 16'h1000, "R4 sw flag set anyway");
    clr_all();
    errcmd = 3'b111;

    // simultaneous rises
    sw_evt = 1; thr_evt = 1; tick(3'b100, "R6 combined pulse");
    tick(3'b000, "R6 single cycle");
    rd(8'hC8, 16'h1080, "R6 both flags");
    clr_all();
    rd(8'hC8, 16'h0000, "R3 all cleared");

    // set/clear collision
    thr_evt = 1; tick(3'b100, "R5 throttle pulse");
    thr_evt = 1; wr(8'hC8, 16'h0080, 2'b01, 3'b000, "R10 event+clear when set");
    rd(8'hC8, 16'h0080, "R10 flag stays set");
    clr_all();
    lock_evt = 1; wr(8'hC8, 16'h0200, 2'b10, 3'b100, "R10 event+clear when clear");
    rd(8'hC8, 16'h0200, "R10 flag set");
    clr_all();

    // thermal routing
    r_smi = 2'b01; r_sci = 2'b10; r_serr = 2'b10;
    trip = 2'b10; tick(3'b000, "R8 two targets");
    rd(8'hC8, 16'h0000, "R8 flag unchanged");
    trip = 2'b01; tick(3'b010, "R7 smi route");
    rd(8'hC8, 16'h0800, "R7 thermal flag");
    trip = 2'b01; tick(3'b000, "R9 blocked while set");
    rd(8'hC8, 16'h0800, "R9 flag still set");
    clr_all();
    r_serr = 2'b00;
    trip = 2'b11; tick(3'b010, "R7 lowest index wins");
    clr_all();
    trip = 2'b10; tick(3'b001, "R7 sci route");
    rd(8'hC8, 16'h0800, "R7 sci sets flag");
    clr_all();
    r_smi = 2'b00; r_sci = 2'b00; r_serr = 2'b01; pcicmd = 0;
    trip = 2'b01; tick(3'b000, "R7 serr route gated");
    rd(8'hC8, 16'h0000, "R7 no send no flag");
    pcicmd = 1;
    trip = 2'b01; tick(3'b100, "R7 serr route");
    rd(8'hC8, 16'h0800, "R7 serr sets flag");
    clr_all();
    r_serr = 2'b00;
    trip = 2'b01; tick(3'b000, "R8 no target");
    rd(8'hC8, 16'h0000, "R8 flag unchanged none");

    // reset domains
    lock_evt = 1; tick(3'b100, "R5 lock before warm reset");
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 warm reset pulses low", {13'd0, serr, smi, sci}, 16'h0);
    rd(8'hC8, 16'h0200, "R11 flags survive warm reset");
    lock_evt = 1; tick(3'b000, "R11 still set no pulse");
    pg_rst_n = 0;
    @(negedge clk);
    pg_rst_n = 1;
    @(negedge clk);
    rd(8'hC8, 16'h0000, "R11 power-good clears");

    @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule